// File: doc/BRIEF.md
# Power-on configuration strap capture unit

This unit reads a small set of board-level configuration pins once, just after power-on reset ends, and turns them into held configuration settings for the rest of the chip. A pin pulled high reads as 1. A floating pin reads as 0. The settings cover:

- the level of the interrupt output;
- the width of the host data bus;
- the LED behaviour;
- a computed I/O base address;
- the choice between normal and reversed MII.

The power-on reset input is asynchronous and active low. Inside the unit it goes through a synchronizer: assertion is immediate and release is synchronous. The straps are captured on the first clock edge after the synchronized release. After that they are held, so later activity on those pins has no effect until the next reset.

A ready timer, sized from the clock frequency and the required delay, raises a ready flag a fixed time after reset release. The default is 5 µs at 250 MHz, which is 1250 counted cycles.

Top module: `strap_cfg_top`

## Requirements
- R1: While `por_n` is low, the outputs show the defaults: `irq_active_low`=0, `bus_width`=01 (16-bit), `cfg_err`=0, `led_mode`=0, `io_base`=0x300, `io_base_valid`=1, `rev_mii`=0 and `ready`=0.
- R2: Counting from 1 at the first rising clock edge after `por_n` rises, the straps are captured at edge SYNC_STAGES+1 (edge 3 by default). The outputs keep their defaults after edge SYNC_STAGES. After capture the outputs do not change when the strap pins change.
- R3: `irq_active_low` equals the captured `strap_irq_pol`. A value of 1 means the interrupt is active low.
- R4: The bus width is decoded from {`strap_width_a`,`strap_width_b`}: 00 gives 16-bit, 01 gives 32-bit and 10 gives 8-bit. The `bus_width` output uses the codes 00=8-bit, 01=16-bit and 10=32-bit.
- R5: The reserved strap code 11 sets `cfg_err`=1 and `bus_width`=01 (16-bit). Every other code gives `cfg_err`=0.
- R6: `led_mode` equals the captured `strap_led`.
- R7: Outside 32-bit mode, `io_base` = 0x300 + 0x10 × `strap_iobase`, 10 bits wide, and `io_base_valid`=1.
- R8: In 32-bit mode, `io_base_valid`=0 and `io_base`=0.
- R9: `rev_mii` equals the captured `strap_link`. A value of 1 selects reversed MII.
- R10: `ready` is 0 after rising edge READY_CYCLES+SYNC_STAGES-1 after `por_n` rises, and 1 after edge READY_CYCLES+SYNC_STAGES. Edge 1252 is the first edge with ready high by default. It then stays 1 until the next reset.
- R11: A falling `por_n` returns every output to the R1 defaults at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| strap_irq_pol | input | 1 | Interrupt polarity strap |
| strap_width_a | input | 1 | Bus width strap, upper code bit |
| strap_width_b | input | 1 | Bus width strap, lower code bit |
| strap_led | input | 1 | LED mode strap |
| strap_iobase | input | 3 | I/O base select straps |
| strap_link | input | 1 | Reverse MII strap, shared with the link pin |
| irq_active_low | output | 1 | 1 when the interrupt is active low |
| bus_width | output | 2 | 00=8-bit, 01=16-bit, 10=32-bit |
| cfg_err | output | 1 | Reserved bus width code was strapped |
| led_mode | output | 1 | LED mode select |
| io_base | output | 10 | Decoded I/O base address |
| io_base_valid | output | 1 | I/O base is meaningful (not 32-bit mode) |
| rev_mii | output | 1 | Reversed MII selected |
| ready | output | 1 | Configuration complete and timer expired |

## Verification
The decoded settings are due after rising edge 3 following the release of `por_n`: two synchronizer stages, then one capture register, with the decode purely combinational behind it. The checks therefore sample at the falling edge after edge 2 to confirm the defaults, and at the falling edge after edge 3 to confirm the captured values. Ready is due after edge 1252, and the bench samples it at the falling edges after edges 1251 and 1252. The asynchronous clear is checked 1 ns after `por_n` falls, in the middle of a clock phase.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  // Host bus width codes as presented on the bus_width output
  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bus_w_e;

  // Raw strap levels as captured
  typedef struct packed {
    logic       irq_pol;
    logic [1:0] wsel;
    logic       led;
    logic [2:0] iob;
    logic       rmii;
  } strap_raw_t;

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strap_raw_t raw_i,
  output strap_raw_t raw_o,
  output logic       sampled_o
);

  strap_raw_t raw_q;
  logic       sampled_q;
  logic       cap_en;
  logic       sampled_d;

  always_comb begin
    cap_en    = !sampled_q;
    sampled_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= '0;
      sampled_q <= 1'b0;
    end else begin
      sampled_q <= sampled_d;
      if (cap_en) raw_q <= raw_i;
    end
  end

  assign raw_o     = raw_q;
  assign sampled_o = sampled_q;

  // R2
  property p_hold;
    @(posedge clk) disable iff (!rst_n) sampled_q |=> $stable(raw_q);
  endproperty
  straps_held_chk: assert property (p_hold);

endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h300,
  parameter int STEP   = 'h10
) (
  input  strap_raw_t        raw_i,
  output logic              irq_active_low_o,
  output bus_w_e            bus_width_o,
  output logic              cfg_err_o,
  output logic              led_mode_o,
  output logic [ADDR_W-1:0] io_base_o,
  output logic              io_base_valid_o,
  output logic              rev_mii_o
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  always_comb begin
    cfg_err_o = 1'b0;
    unique case (raw_i.wsel)
      2'b00:   bus_width_o = BW_16;
      2'b01:   bus_width_o = BW_32;
      2'b10:   bus_width_o = BW_8;
      default: begin
        bus_width_o = BW_16;
        cfg_err_o   = 1'b1;
      end
    endcase
    io_base_valid_o  = (bus_width_o != BW_32);
    io_base_o        = io_base_valid_o ? (BASE_A + ADDR_W'(raw_i.iob) * STEP_A) : '0;
    irq_active_low_o = raw_i.irq_pol;
    led_mode_o       = raw_i.led;
    rev_mii_o        = raw_i.rmii;
  end

endmodule

// File: rtl/strap_ready_timer.sv
module strap_ready_timer #(
  parameter int LIMIT = 1250
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LIM);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = !cnt_en;

  // R10
  property p_ready_stays;
    @(posedge clk) disable iff (!rst_n) ready_o |=> ready_o;
  endproperty
  ready_sticky_chk: assert property (p_ready_stays);

endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int READY_NS    = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       strap_irq_pol,
  input  logic       strap_width_a,
  input  logic       strap_width_b,
  input  logic       strap_led,
  input  logic [2:0] strap_iobase,
  input  logic       strap_link,
  output logic       irq_active_low,
  output logic [1:0] bus_width,
  output logic       cfg_err,
  output logic       led_mode,
  output logic [9:0] io_base,
  output logic       io_base_valid,
  output logic       rev_mii,
  output logic       ready
);

  localparam int READY_CYCLES = CLK_MHZ * READY_NS / 1000;

  logic       rst_n_s;
  logic       sampled;
  strap_raw_t raw_in;
  strap_raw_t raw_held;
  bus_w_e     bw;

  always_comb begin
    raw_in.irq_pol = strap_irq_pol;
    raw_in.wsel    = {strap_width_a, strap_width_b};
    raw_in.led     = strap_led;
    raw_in.iob     = strap_iobase;
    raw_in.rmii    = strap_link;
  end

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .rst_n_o(rst_n_s)
  );

  strap_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .raw_i    (raw_in),
    .raw_o    (raw_held),
    .sampled_o(sampled)
  );

  strap_decode #(.ADDR_W(10), .BASE('h300), .STEP('h10)) u_dec (
    .raw_i           (raw_held),
    .irq_active_low_o(irq_active_low),
    .bus_width_o     (bw),
    .cfg_err_o       (cfg_err),
    .led_mode_o      (led_mode),
    .io_base_o       (io_base),
    .io_base_valid_o (io_base_valid),
    .rev_mii_o       (rev_mii)
  );

  assign bus_width = bw;

  strap_ready_timer #(.LIMIT(READY_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ready_o(ready)
  );

  // R2
  property p_ready_after_cap;
    @(posedge clk) disable iff (!rst_n_s) ready |-> sampled;
  endproperty
  ready_after_cap_chk: assert property (p_ready_after_cap);

  // R5
  property p_err_fallback;
    @(posedge clk) disable iff (!rst_n_s) cfg_err |-> (bus_width == 2'b01);
  endproperty
  err_fallback_chk: assert property (p_err_fallback);

  // R7
  property p_io_range;
    @(posedge clk) disable iff (!rst_n_s)
      io_base_valid |-> (io_base[9:8] == 2'b11 && io_base[3:0] == 4'h0 && io_base[7] == 1'b0);
  endproperty
  io_range_chk: assert property (p_io_range);

  // R8
  property p_io_wide;
    @(posedge clk) disable iff (!rst_n_s) (bus_width == 2'b10) |-> (!io_base_valid && io_base == '0);
  endproperty
  io_wide_chk: assert property (p_io_wide);

endmodule

// File: tb/strap_cfg_top_tb_top.sv
`timescale 1ns/1ps
module strap_cfg_top_tb_top;

  localparam int L = 250 * 5000 / 1000;

  typedef struct {
    logic       irq;
    logic [1:0] bw;
    logic       err;
    logic       led;
    logic [9:0] iob;
    logic       iobv;
    logic       rmii;
    string      ctx;
  } exp_t;

  logic       clk = 1'b0;
  logic       por_n;
  logic       s_ip, s_wa, s_wb, s_ld, s_lk;
  logic [2:0] s_n;
  logic       irq_active_low, cfg_err, led_mode, io_base_valid, rev_mii, ready;
  logic [1:0] bus_width;
  logic [9:0] io_base;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t sbq[$];
  event chk_ev;

  always #2 clk = ~clk;

  strap_cfg_top dut_i (
    .clk(clk), .por_n(por_n),
    .strap_irq_pol(s_ip), .strap_width_a(s_wa), .strap_width_b(s_wb),
    .strap_led(s_ld), .strap_iobase(s_n), .strap_link(s_lk),
    .irq_active_low(irq_active_low), .bus_width(bus_width), .cfg_err(cfg_err),
    .led_mode(led_mode), .io_base(io_base), .io_base_valid(io_base_valid),
    .rev_mii(rev_mii), .ready(ready)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic ip, wa, wb, ld, input logic [2:0] n,
                                 input logic lk, input string ctx);
    exp_t e;
    e.irq  = ip;
    e.led  = ld;
    e.rmii = lk;
    e.err  = (wa && wb);
    case ({wa, wb})
      2'b00:   e.bw = 2'b01;
      2'b01:   e.bw = 2'b10;
      2'b10:   e.bw = 2'b00;
      default: e.bw = 2'b01;
    endcase
    e.iobv = (e.bw != 2'b10);
    e.iob  = e.iobv ? (10'h300 + 10'(n) * 10'h10) : 10'h000;
    e.ctx  = ctx;
    return e;
  endfunction

  // Monitor: pops one expected item per request and compares field by field
  always begin
    exp_t e;
    @(chk_ev);
    e = sbq.pop_front();
    chk({e.ctx, " R3 irq"},  16'(irq_active_low), 16'(e.irq));
    chk({e.ctx, " R4 bw"},   16'(bus_width),      16'(e.bw));
    chk({e.ctx, " R5 err"},  16'(cfg_err),        16'(e.err));
    chk({e.ctx, " R6 led"},  16'(led_mode),       16'(e.led));
    chk({e.ctx, " R7 iob"},  16'(io_base),        16'(e.iob));
    chk({e.ctx, " R8 iobv"}, 16'(io_base_valid),  16'(e.iobv));
    chk({e.ctx, " R9 rmii"}, 16'(rev_mii),        16'(e.rmii));
  end

  task automatic push_chk(input exp_t e);
    sbq.push_back(e);
    -> chk_ev;
    #0.5;
  endtask

  task automatic run_case(input logic ip, wa, wb, ld, input logic [2:0] n, input logic lk);
    exp_t e;
    s_ip = ip; s_wa = wa; s_wb = wb; s_ld = ld; s_n = n; s_lk = lk;
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    push_chk(model(0, 0, 0, 0, 3'd0, 0, "R1 in reset"));
    chk("R1 ready in reset", 16'(ready), 16'd0);
    @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    push_chk(model(0, 0, 0, 0, 3'd0, 0, "R2 before capture"));
    @(posedge clk);
    @(negedge clk);
    e = model(ip, wa, wb, ld, n, lk, "R2 captured");
    push_chk(e);
    s_ip = ~ip; s_wa = ~wa; s_wb = ~wb; s_ld = ~ld; s_n = ~n; s_lk = ~lk;
    repeat (3) @(negedge clk);
    e.ctx = "R2 held after strap change";
    push_chk(e);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0;
    s_ip = 0; s_wa = 0; s_wb = 0; s_ld = 0; s_n = 0; s_lk = 0;
    run_case(1, 0, 0, 0, 3'd5, 1);   // 16-bit, base 0x350
    run_case(0, 0, 1, 1, 3'd7, 0);   // 32-bit, base invalid
    run_case(1, 1, 0, 1, 3'd0, 1);   // 8-bit, base 0x300
    run_case(0, 1, 1, 0, 3'd2, 0);   // reserved -> 16-bit + error, base 0x320
    run_case(1, 0, 0, 1, 3'd7, 1);   // 16-bit, top base 0x370

    // R10: ready timing, counted from the release of por_n
    por_n = 1'b0;
    s_ip = 1; s_wa = 0; s_wb = 0; s_ld = 1; s_n = 3'd4; s_lk = 1;
    @(negedge clk);
    por_n = 1'b1;
    repeat (L + 1) @(posedge clk);
    @(negedge clk);
    chk("R10 ready one edge early", 16'(ready), 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 ready due", 16'(ready), 16'd1);
    repeat (20) @(negedge clk);
    chk("R10 ready stays", 16'(ready), 16'd1);

    // R11: asynchronous clear mid-cycle
    #1;
    por_n = 1'b0;
    #1;
    chk("R11 ready cleared", 16'(ready), 16'd0);
    push_chk(model(0, 0, 0, 0, 3'd0, 0, "R11 async clear"));

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule